// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the register front end of a raster LCD controller. A simple 32-bit register bus reaches it through a 4 KB window that is addressed in 32-bit words. The block keeps four timing words, the upper and lower frame base addresses, a control word, an interrupt enable mask and a raw interrupt status. From the timing words it works out the panel width and height. A slice of the window is passed through to an external palette store, and the top words of the window return fixed identification bytes. Any write, whatever its target, raises a one-cycle invalidate pulse so that the display path knows to redraw. A single interrupt output follows the status bits that the mask enables.

The bus has no back-pressure. A write (`bus_wr`) or a read (`bus_rd`) is accepted in the cycle it is asserted. Read data is registered: it appears on `bus_rdata` with `bus_rvalid` high one cycle after the request, and it holds until the next read. Palette accesses are forwarded in the same cycle on the palette port. The palette store must return `pal_rdata` combinationally for the `pal_idx` it is given. A parameter `VARIANT` selects the layout: 0 is the base part, 1 is the board variant and 2 is the extended part.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every register reads zero. `irq`, `inval`, `ctrl_word`, `upper_base` and `lower_base` are zero, `panel_cols` is 16 and `panel_rows` is 1.
- R2: Word indices 0..3 hold the timing words, index 4 holds the upper base and index 5 holds the lower base. Each one reads back the full 32-bit value last written to it.
- R3: When VARIANT is 0, index 6 is the interrupt mask and index 7 is the control word. For any other VARIANT the two indices are exchanged, for both reads and writes. Only the low NIRQ bits of the mask are stored. The control word drives `ctrl_word`.
- R4: `panel_cols` = ((timing0 & 0xFC) + 4) × 4 and `panel_rows` = (timing1 & 0x3FF) + 1.
- R5: Word indices 0x3F8..0x3FF (byte offsets 0xFE0..0xFFC) read one identification byte each, zero-extended. The sequence is 10 11 04 00 0D F0 05 B1 for VARIANT 0 or 1, and 11 11 24 00 0D F0 05 B1 for VARIANT 2.
- R6: Word indices 0x80..0xFF (byte offsets 0x200..0x3FF) form the palette window. A write there pulses `pal_wr` in the same cycle, with `pal_idx` = index − 0x80 and `pal_wdata` = write data. A read there returns `pal_rdata`. No access outside the window asserts `pal_wr`.
- R7: Index 8 reads the raw status and index 9 reads the raw status ANDed with the mask. `irq` is a register that holds the OR of the masked status one cycle later.
- R8: A raw status bit is set by a high `irq_evt` bit. A write to index 10 clears every raw bit whose write-data bit is 1. When a set and a clear hit the same bit in the same cycle, the set wins.
- R9: Index 11 reads the upper base and index 12 reads the lower base. Writes to these indices have no effect.
- R10: Every accepted write drives `inval` high for exactly the following cycle. `inval` is low in a cycle that follows no write.
- R11: Every index not named above reads zero, and writes to it change nothing. Writes to indices 8 and 9 also change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request, accepted in the same cycle |
| bus_rd | input | 1 | Read request, accepted in the same cycle |
| bus_widx | input | 10 | Word index within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High in the cycle after a read |
| pal_wr | output | 1 | Palette write strobe |
| pal_rd | output | 1 | Palette read strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data for `pal_idx` |
| irq_evt | input | 5 | Interrupt event inputs, one per status bit |
| irq | output | 1 | Registered OR of the masked status |
| inval | output | 1 | One-cycle display invalidate pulse |
| panel_cols | output | 11 | Panel width in pixels |
| panel_rows | output | 11 | Panel height in lines |
| ctrl_word | output | 32 | Control register contents |
| upper_base | output | 32 | Upper frame base address |
| lower_base | output | 32 | Lower frame base address |

## Verification
The hardest case to reach is a collision in the status register: an event and a clear write hitting the same bit in one cycle. The bench drives `irq_evt` and a clear write on the same falling edge, so both are seen at one rising edge. It then reads the raw status to confirm that the colliding bit stayed set while the other bit was cleared. The swapped mask and control positions cannot be seen with a single layout. A second instance built with the extended layout therefore shares the bus, and after the same write the bench compares `ctrl_word` and the readback of the two instances.

// File: rtl/lcdc_pkg.sv
`timescale 1ns/1ps
package lcdc_pkg;

  localparam int VAR_BASE  = 0;
  localparam int VAR_BOARD = 1;
  localparam int VAR_EXT   = 2;

  typedef enum logic [3:0] {
    K_NONE, K_TIM, K_UBASE, K_LBASE, K_MASK, K_CTRL,
    K_RAW, K_MSTAT, K_CLR, K_UCUR, K_LCUR, K_PAL, K_ID
  } kind_e;

  function automatic logic [7:0] id_byte(input int variant, input logic [2:0] pos);
    case (pos)
      3'd0:    return (variant == VAR_EXT) ? 8'h11 : 8'h10;
      3'd1:    return 8'h11;
      3'd2:    return (variant == VAR_EXT) ? 8'h24 : 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_addr_dec.sv
`timescale 1ns/1ps
module lcdc_addr_dec
  import lcdc_pkg::*;
#(
  parameter int WIDX_W    = 10,
  parameter int PAL_WORDS = 128,
  parameter int PAL_BASE  = 128,
  parameter int ID_BASE   = 1016,
  parameter int VARIANT   = 0
) (
  input  logic [WIDX_W-1:0]            widx,
  output kind_e                        kind,
  output logic [1:0]                   tim_sel,
  output logic [$clog2(PAL_WORDS)-1:0] pal_idx,
  output logic [2:0]                   id_idx
);
  localparam int PAL_IDX_W = $clog2(PAL_WORDS);
  localparam logic [WIDX_W-1:0] PAL_LO = WIDX_W'(PAL_BASE);
  localparam logic [WIDX_W-1:0] PAL_HI = WIDX_W'(PAL_BASE + PAL_WORDS - 1);
  localparam logic [WIDX_W-1:0] ID_LO  = WIDX_W'(ID_BASE);

  kind_e kind_six, kind_seven;

  generate
    if (VARIANT == VAR_BASE) begin : g_plain
      assign kind_six   = K_MASK;
      assign kind_seven = K_CTRL;
    end else begin : g_swapped
      assign kind_six   = K_CTRL;
      assign kind_seven = K_MASK;
    end
  endgenerate

  assign tim_sel = widx[1:0];
  assign pal_idx = widx[PAL_IDX_W-1:0];
  assign id_idx  = widx[2:0];

  always_comb begin
    kind = K_NONE;
    if (widx >= PAL_LO && widx <= PAL_HI) begin
      kind = K_PAL;
    end else if (widx >= ID_LO) begin
      kind = K_ID;
    end else begin
      case (int'(widx))
        0, 1, 2, 3: kind = K_TIM;
        4:          kind = K_UBASE;
        5:          kind = K_LBASE;
        6:          kind = kind_six;
        7:          kind = kind_seven;
        8:          kind = K_RAW;
        9:          kind = K_MSTAT;
        10:         kind = K_CLR;
        11:         kind = K_UCUR;
        12:         kind = K_LCUR;
        default:    kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/lcdc_irq_unit.sv
`timescale 1ns/1ps
module lcdc_irq_unit #(
  parameter int NIRQ = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] evt,
  input  logic            mask_we,
  input  logic [NIRQ-1:0] mask_wdata,
  input  logic            clr_we,
  input  logic [NIRQ-1:0] clr_wdata,
  output logic [NIRQ-1:0] raw,
  output logic [NIRQ-1:0] mask,
  output logic            irq
);
  logic [NIRQ-1:0] clr_vec;

  assign clr_vec = clr_we ? clr_wdata : '0;

  // Set after clear: an event in the same cycle keeps its bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
    end else begin
      raw <= (raw & ~clr_vec) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (mask_we) begin
      mask <= mask_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= |(raw & mask);
    end
  end

endmodule

// File: rtl/lcdc_geom.sv
`timescale 1ns/1ps
module lcdc_geom #(
  parameter int DIM_W = 11
) (
  input  logic [5:0]       hfield,
  input  logic [9:0]       vfield,
  output logic [DIM_W-1:0] cols,
  output logic [DIM_W-1:0] rows
);
  // ((t0 & 0xFC) + 4) * 4 equals (t0[7:2] + 1) * 16.
  assign cols = (DIM_W'(hfield) + DIM_W'(1)) << 4;
  assign rows = DIM_W'(vfield) + DIM_W'(1);
endmodule

// File: rtl/lcdc_regs.sv
`timescale 1ns/1ps
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int WIDX_W    = 10,
  parameter int DATA_W    = 32,
  parameter int NIRQ      = 5,
  parameter int PAL_WORDS = 128,
  parameter int VARIANT   = 0,
  parameter int DIM_W     = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [WIDX_W-1:0]            bus_widx,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic                         bus_rvalid,
  output logic                         pal_wr,
  output logic                         pal_rd,
  output logic [$clog2(PAL_WORDS)-1:0] pal_idx,
  output logic [DATA_W-1:0]            pal_wdata,
  input  logic [DATA_W-1:0]            pal_rdata,
  input  logic [NIRQ-1:0]              irq_evt,
  output logic                         irq,
  output logic                         inval,
  output logic [DIM_W-1:0]             panel_cols,
  output logic [DIM_W-1:0]             panel_rows,
  output logic [DATA_W-1:0]            ctrl_word,
  output logic [DATA_W-1:0]            upper_base,
  output logic [DATA_W-1:0]            lower_base
);
  localparam int NTIM      = 4;
  localparam int PAL_IDX_W = $clog2(PAL_WORDS);
  localparam int PAL_BASE  = 128;
  localparam int ID_BASE   = (1 << WIDX_W) - 8;

  kind_e                kind;
  logic [1:0]           tim_sel;
  logic [2:0]           id_idx;
  logic [DATA_W-1:0]    tim_q [NTIM];
  logic [DATA_W-1:0]    ubase_q, lbase_q, ctrl_q;
  logic [NIRQ-1:0]      irq_raw, irq_mask;
  logic [DATA_W-1:0]    rd_mux;
  logic [DATA_W-1:0]    rdata_q;
  logic                 rvalid_q, inval_q;

  lcdc_addr_dec #(
    .WIDX_W    (WIDX_W),
    .PAL_WORDS (PAL_WORDS),
    .PAL_BASE  (PAL_BASE),
    .ID_BASE   (ID_BASE),
    .VARIANT   (VARIANT)
  ) u_dec (
    .widx    (bus_widx),
    .kind    (kind),
    .tim_sel (tim_sel),
    .pal_idx (pal_idx),
    .id_idx  (id_idx)
  );

  genvar g;
  generate
    for (g = 0; g < NTIM; g++) begin : g_tim
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tim_q[g] <= '0;
        end else if (bus_wr && kind == K_TIM && tim_sel == 2'(g)) begin
          tim_q[g] <= bus_wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ubase_q <= '0;
      lbase_q <= '0;
      ctrl_q  <= '0;
    end else if (bus_wr) begin
      if (kind == K_UBASE) ubase_q <= bus_wdata;
      if (kind == K_LBASE) lbase_q <= bus_wdata;
      if (kind == K_CTRL)  ctrl_q  <= bus_wdata;
    end
  end

  lcdc_irq_unit #(.NIRQ(NIRQ)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (irq_evt),
    .mask_we    (bus_wr && kind == K_MASK),
    .mask_wdata (bus_wdata[NIRQ-1:0]),
    .clr_we     (bus_wr && kind == K_CLR),
    .clr_wdata  (bus_wdata[NIRQ-1:0]),
    .raw        (irq_raw),
    .mask       (irq_mask),
    .irq        (irq)
  );

  lcdc_geom #(.DIM_W(DIM_W)) u_geom (
    .hfield (tim_q[0][7:2]),
    .vfield (tim_q[1][9:0]),
    .cols   (panel_cols),
    .rows   (panel_rows)
  );

  always_comb begin
    case (kind)
      K_TIM:           rd_mux = tim_q[tim_sel];
      K_UBASE, K_UCUR: rd_mux = ubase_q;
      K_LBASE, K_LCUR: rd_mux = lbase_q;
      K_MASK:          rd_mux = DATA_W'(irq_mask);
      K_CTRL:          rd_mux = ctrl_q;
      K_RAW:           rd_mux = DATA_W'(irq_raw);
      K_MSTAT:         rd_mux = DATA_W'(irq_raw & irq_mask);
      K_PAL:           rd_mux = pal_rdata;
      K_ID:            rd_mux = DATA_W'(id_byte(VARIANT, id_idx));
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      inval_q  <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      inval_q  <= bus_wr;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign pal_wr     = bus_wr && kind == K_PAL;
  assign pal_rd     = bus_rd && kind == K_PAL;
  assign pal_wdata  = bus_wdata;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign inval      = inval_q;
  assign ctrl_word  = ctrl_q;
  assign upper_base = ubase_q;
  assign lower_base = lbase_q;

endmodule

// File: rtl/lcdc_regs_chk.sv
`timescale 1ns/1ps
module lcdc_regs_chk #(
  parameter int WIDX_W = 10,
  parameter int DATA_W = 32,
  parameter int NIRQ   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [WIDX_W-1:0] bus_widx,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pal_wr,
  input logic              inval,
  input logic              irq,
  input logic [NIRQ-1:0]   irq_evt,
  input logic [NIRQ-1:0]   irq_mask
);
  localparam logic [WIDX_W-1:0] PAL_LO  = WIDX_W'(128);
  localparam logic [WIDX_W-1:0] PAL_HI  = WIDX_W'(255);
  localparam logic [WIDX_W-1:0] LAST_RG = WIDX_W'(12);
  localparam logic [WIDX_W-1:0] ID_FOUR = WIDX_W'((1 << WIDX_W) - 4);

  AST_INVAL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> inval); // R10

  AST_INVAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !inval); // R10

  AST_PAL_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pal_wr |-> (bus_wr && bus_widx >= PAL_LO && bus_widx <= PAL_HI)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_widx > LAST_RG && bus_widx < PAL_LO) |=> bus_rdata == '0); // R11

  AST_ID_FIXED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_widx == ID_FOUR) |=> bus_rdata == DATA_W'(8'h0D)); // R5

  AST_IRQ_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(irq_evt & irq_mask)) && !bus_wr) |-> ##2 irq); // R7

endmodule

bind lcdc_regs lcdc_regs_chk #(
  .WIDX_W (WIDX_W),
  .DATA_W (DATA_W),
  .NIRQ   (NIRQ)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_widx  (bus_widx),
  .bus_rdata (bus_rdata),
  .pal_wr    (pal_wr),
  .inval     (inval),
  .irq       (irq),
  .irq_evt   (irq_evt),
  .irq_mask  (irq_mask)
);

// File: tb/lcdc_regs_bench.sv
`timescale 1ns/1ps
module lcdc_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_widx = '0;
  logic [31:0] bus_wdata = '0;
  logic [4:0]  irq_evt = '0;

  logic [31:0] rdata0, rdata2, pwdata0, pwdata2, prdata0, prdata2;
  logic        rvalid0, rvalid2, pwr0, pwr2, prd0, prd2;
  logic [6:0]  pidx0, pidx2;
  logic        irq0, irq2, inval0, inval2;
  logic [10:0] cols0, rows0, cols2, rows2;
  logic [31:0] ctrl0, ctrl2, ub0, ub2, lb0, lb2;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  // Palette store models: data depends on the index only.
  assign prdata0 = {16'hC0DE, 9'd0, pidx0};
  assign prdata2 = {16'hC0DE, 9'd0, pidx2};

  lcdc_regs #(.VARIANT(0)) u_lcdc_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
    .bus_rvalid(rvalid0), .pal_wr(pwr0), .pal_rd(prd0), .pal_idx(pidx0),
    .pal_wdata(pwdata0), .pal_rdata(prdata0), .irq_evt(irq_evt), .irq(irq0),
    .inval(inval0), .panel_cols(cols0), .panel_rows(rows0),
    .ctrl_word(ctrl0), .upper_base(ub0), .lower_base(lb0)
  );

  lcdc_regs #(.VARIANT(2)) u_lcdc_regs_ext (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
    .bus_rvalid(rvalid2), .pal_wr(pwr2), .pal_rd(prd2), .pal_idx(pidx2),
    .pal_wdata(pwdata2), .pal_rdata(prdata2), .irq_evt(irq_evt), .irq(irq2),
    .inval(inval2), .panel_cols(cols2), .panel_rows(rows2),
    .ctrl_word(ctrl2), .upper_base(ub2), .lower_base(lb2)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [9:0]  widx;
    logic [31:0] wdat;
    logic [31:0] expv;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  10'd0,   32'h12345678, 32'h12345678}, // R2
    '{8'd2,  10'd1,   32'hFFFFFFFF, 32'hFFFFFFFF}, // R2
    '{8'd2,  10'd2,   32'hA5A5A5A5, 32'hA5A5A5A5}, // R2
    '{8'd2,  10'd3,   32'h0000BEEF, 32'h0000BEEF}, // R2
    '{8'd2,  10'd4,   32'h80001000, 32'h80001000}, // R2
    '{8'd2,  10'd5,   32'h80002000, 32'h80002000}, // R2
    '{8'd3,  10'd6,   32'hFFFFFFFF, 32'h0000001F}, // R3 mask keeps NIRQ bits
    '{8'd3,  10'd7,   32'h00000C2B, 32'h00000C2B}, // R3 control
    '{8'd9,  10'd11,  32'h00001234, 32'h80001000}, // R9
    '{8'd9,  10'd12,  32'h00005678, 32'h80002000}, // R9
    '{8'd11, 10'd8,   32'hFFFFFFFF, 32'h00000000}, // R11 raw status not writable
    '{8'd11, 10'd13,  32'hDEADBEEF, 32'h00000000}, // R11
    '{8'd11, 10'd127, 32'h0000CAFE, 32'h00000000}  // R11
  };

  logic        inval_s, pwr_s;
  logic [6:0]  pidx_s;
  logic [31:0] pwdata_s;
  logic [31:0] d0, d2;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic do_wr(input logic [9:0] idx, input logic [31:0] dat);
    @(negedge clk);
    bus_wr = 1'b1; bus_widx = idx; bus_wdata = dat;
    #1;
    pwr_s = pwr0; pidx_s = pidx0; pwdata_s = pwdata0;
    @(negedge clk);
    bus_wr = 1'b0;
    inval_s = inval0;
  endtask

  task automatic do_rd(input logic [9:0] idx);
    @(negedge clk);
    bus_rd = 1'b1; bus_widx = idx;
    @(negedge clk);
    bus_rd = 1'b0;
    d0 = rdata0; d2 = rdata2;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq0), 0);
    chk("R1 inval", 32'(inval0), 0);
    chk("R1 cols", 32'(cols0), 16);
    chk("R1 rows", 32'(rows0), 1);
    chk("R1 ctrl", ctrl0, 0);
    chk("R1 ubase", ub0, 0);
    chk("R1 lbase", lb0, 0);
    do_rd(10'd0); chk("R1 timing0", d0, 0);
    do_rd(10'd6); chk("R1 mask", d0, 0);

    for (int i = 0; i < NV; i++) begin
      do_wr(VECS[i].widx, VECS[i].wdat);
      chk("R10 inval after write", 32'(inval_s), 1);
      do_rd(VECS[i].widx);
      chk($sformatf("R%0d idx %0d", VECS[i].req, VECS[i].widx), d0, VECS[i].expv);
    end
    @(negedge clk);
    chk("R10 inval idle", 32'(inval0), 0);
    chk("R9 upper_base port", ub0, 32'h80001000);
    chk("R9 lower_base port", lb0, 32'h80002000);
    chk("R3 ctrl_word port", ctrl0, 32'h00000C2B);

    // R4 panel geometry
    chk("R4 cols from 0x78", 32'(cols0), 496);
    chk("R4 rows from 0x3FF", 32'(rows0), 1024);
    do_wr(10'd0, 32'h000000FF); @(negedge clk);
    chk("R4 cols max", 32'(cols0), 1024);
    do_wr(10'd0, 32'hFFFFFF03); @(negedge clk);
    chk("R4 cols min", 32'(cols0), 16);
    do_wr(10'd1, 32'h00000400); @(negedge clk);
    chk("R4 rows wrap", 32'(rows0), 1);

    // R5 identification bytes
    do_rd(10'h3F8); chk("R5 id0 base", d0, 32'h10); chk("R5 id0 ext", d2, 32'h11);
    do_rd(10'h3F9); chk("R5 id1", d0, 32'h11);
    do_rd(10'h3FA); chk("R5 id2 base", d0, 32'h04); chk("R5 id2 ext", d2, 32'h24);
    do_rd(10'h3FB); chk("R5 id3", d0, 32'h00);
    do_rd(10'h3FC); chk("R5 id4", d0, 32'h0D);
    do_rd(10'h3FD); chk("R5 id5", d0, 32'hF0);
    do_rd(10'h3FE); chk("R5 id6", d0, 32'h05);
    do_rd(10'h3FF); chk("R5 id7", d0, 32'hB1);

    // R6 palette window
    do_wr(10'h081, 32'h00007FFF);
    chk("R6 pal_wr", 32'(pwr_s), 1);
    chk("R6 pal_idx", 32'(pidx_s), 1);
    chk("R6 pal_wdata", pwdata_s, 32'h00007FFF);
    do_wr(10'h07F, 32'h1);
    chk("R6 no pal_wr below window", 32'(pwr_s), 0);
    do_wr(10'h100, 32'h1);
    chk("R6 no pal_wr above window", 32'(pwr_s), 0);
    do_rd(10'h0FF); chk("R6 read last", d0, 32'hC0DE007F);
    do_rd(10'h080); chk("R6 read first", d0, 32'hC0DE0000);

    // R3 swapped layout on the extended instance
    do_wr(10'd6, 32'h00000ABC);
    @(negedge clk);
    chk("R3 ext ctrl at 6", ctrl2, 32'h00000ABC);
    chk("R3 base ctrl unchanged", ctrl0, 32'h00000C2B);
    do_rd(10'd7);
    chk("R3 ext mask at 7", d2, 32'h0000000B);
    chk("R3 base ctrl at 7", d0, 32'h00000C2B);

    // R7 / R8 interrupts
    do_wr(10'd6, 32'h1F);
    @(negedge clk); irq_evt = 5'b00101;
    @(negedge clk); irq_evt = 5'b00000;
    chk("R7 irq one cycle late", 32'(irq0), 0);
    @(negedge clk);
    chk("R7 irq raised", 32'(irq0), 1);
    do_rd(10'd8); chk("R8 raw set", d0, 32'h05);
    do_rd(10'd9); chk("R7 masked all", d0, 32'h05);
    do_wr(10'd6, 32'h01);
    do_rd(10'd9); chk("R7 masked partial", d0, 32'h01);
    chk("R7 irq kept", 32'(irq0), 1);
    @(negedge clk);
    bus_wr = 1'b1; bus_widx = 10'd10; bus_wdata = 32'h05; irq_evt = 5'b00001;
    @(negedge clk);
    bus_wr = 1'b0; irq_evt = 5'b00000;
    do_rd(10'd8); chk("R8 set wins over clear", d0, 32'h01);
    do_wr(10'd10, 32'h01);
    do_rd(10'd8); chk("R8 clear", d0, 32'h00);
    @(negedge clk);
    chk("R7 irq dropped", 32'(irq0), 0);

    finish_run();
  end

endmodule